// File: doc/BRIEF.md
# Dual-Mode Reduced-Pin Ethernet Transmit Shaper

The shaper takes bytes from a MAC transmit path and turns them into the signals a PHY expects on a reduced-pin Ethernet link. Two static inputs choose the link. One chooses between RGMII, with a four-bit nibble path, and RMII, with a two-bit dibit path. The other chooses the line rate: 1000, 100 or 10 Mb/s. For each transmit clock the block gives a four-bit data value and a control bit, each split into a rising-edge half and a falling-edge half. An external double-rate output cell places these halves on the pins.

The MAC side is a byte stream with valid, error and ready signals. The block accepts a byte only when the previous byte has been fully serialized. This limits the MAC to the line rate without any buffering. When no byte is in flight, the data halves are zero and the control line is low. Preamble, CRC, clock generation and the output cells stay outside the block.

Top module: `phy_tx_shaper`

## Requirements
- R1: While reset is active and in the first cycle after it, every data half and control half is zero and `in_ready` is high.
- R2: In RGMII at 1000 Mb/s (`cfg_speed` 2 or 3), the cycle after a byte is accepted shows bits [3:0] on `txd_rise` and bits [7:4] on `txd_fall`, and `in_ready` is high every cycle.
- R3: In RGMII at 100 or 10 Mb/s (`cfg_speed` 1 or 0), an accepted byte takes two cycles: bits [3:0] in the first and bits [7:4] in the second, with `txd_rise` equal to `txd_fall`.
- R4: In RMII at 100 Mb/s (`cfg_rmii`=1 with `cfg_speed` not 0), an accepted byte takes four cycles on data bits [1:0], in the order bits [1:0], [3:2], [5:4], [7:6]. Data bits [3:2] stay zero and both halves are equal.
- R5: In RMII at 10 Mb/s (`cfg_speed` 0), each dibit and the control line are held for 10 consecutive cycles, so one byte lasts 40 cycles.
- R6: In RGMII, while a byte is on the bus, `ctl_rise` is 1 and `ctl_fall` is the inverse of the byte's error flag (enable XOR error).
- R7: In RMII, both control halves are 1 exactly while a byte is on the bus, and the error flag has no effect on them.
- R8: When no byte is in flight, all data halves are zero and both control halves are low.
- R9: `in_ready` is high only when the bus is idle or the current byte is in its last cycle. A byte offered while `in_ready` is low is ignored. With continuous valid input, bytes follow back to back with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rmii | input | 1 | 1 = RMII dibit link, 0 = RGMII nibble link |
| cfg_speed | input | 2 | 0 = 10 Mb/s, 1 = 100 Mb/s, 2 or 3 = 1000 Mb/s |
| in_data | input | 8 | Byte from the MAC |
| in_valid | input | 1 | `in_data` holds a byte |
| in_err | input | 1 | Error flag for the offered byte |
| in_ready | output | 1 | Block accepts the offered byte this cycle |
| txd_rise | output | 4 | Data half for the rising edge |
| txd_fall | output | 4 | Data half for the falling edge |
| ctl_rise | output | 1 | Control half for the rising edge |
| ctl_fall | output | 1 | Control half for the falling edge |

## Verification
The bench sweeps all five link settings with byte streams that contain gaps, error flags on some bytes, and garbage data offered while `in_ready` is low. It compares every output in every cycle against a model that computes the symbol index from the cycles elapsed since acceptance.

- A design that swapped nibble or dibit order would put the high bits first.
- A design that miscounted the ten-cycle hold at RMII 10 Mb/s would move to the next dibit too early or too late, and `in_ready` would drift from its 40-cycle period.
- A design that latched data while `in_ready` is low would show the inverted garbage byte.
- A design that dropped the idle gate would leave stale data on the bus after the last byte.

// File: rtl/phy_tx_shaper.sv
module phy_tx_shaper #(
  parameter int SLOW_REPEAT = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_rmii,
  input  logic [1:0] cfg_speed,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_err,
  output logic       in_ready,
  output logic [3:0] txd_rise,
  output logic [3:0] txd_fall,
  output logic       ctl_rise,
  output logic       ctl_fall
);

  localparam int RW = $clog2(SLOW_REPEAT + 1);

  logic          act;
  logic          err_q;
  logic [7:0]    hold;
  logic [1:0]    sym;
  logic [RW-1:0] rep;

  logic          gig;
  logic          rmii_slow;
  logic [1:0]    last_sym;
  logic [RW-1:0] last_rep;
  logic          done;
  logic [3:0]    nib;
  logic [1:0]    dib;

  assign gig       = cfg_speed[1];
  assign rmii_slow = cfg_rmii && (cfg_speed == 2'd0);
  assign last_sym  = cfg_rmii ? 2'd3 : (gig ? 2'd0 : 2'd1);
  assign last_rep  = rmii_slow ? RW'(SLOW_REPEAT - 1) : '0;
  assign done      = (sym == last_sym) && (rep == last_rep);
  assign in_ready  = !act || done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act   <= 1'b0;
      err_q <= 1'b0;
      hold  <= '0;
      sym   <= '0;
      rep   <= '0;
    end else if (in_ready) begin
      act   <= in_valid;
      err_q <= in_valid && in_err;
      hold  <= in_valid ? in_data : 8'h00;
      sym   <= '0;
      rep   <= '0;
    end else if (rep == last_rep) begin
      rep <= '0;
      sym <= sym + 2'd1;
    end else begin
      rep <= rep + 1'b1;
    end
  end

  assign nib = sym[0] ? hold[7:4] : hold[3:0];

  always_comb begin
    case (sym)
      2'd0:    dib = hold[1:0];
      2'd1:    dib = hold[3:2];
      2'd2:    dib = hold[5:4];
      default: dib = hold[7:6];
    endcase
  end

  always_comb begin
    txd_rise = 4'h0;
    txd_fall = 4'h0;
    ctl_rise = 1'b0;
    ctl_fall = 1'b0;
    if (act) begin
      ctl_rise = 1'b1;
      if (cfg_rmii) begin
        txd_rise = {2'b00, dib};
        txd_fall = {2'b00, dib};
        ctl_fall = 1'b1;
      end else begin
        ctl_fall = !err_q;
        if (gig) begin
          txd_rise = hold[3:0];
          txd_fall = hold[7:4];
        end else begin
          txd_rise = nib;
          txd_fall = nib;
        end
      end
    end
  end

  a_r2_gig_always_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_rmii && gig) |-> in_ready);

  a_r3_single_rate: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rmii || !gig) |-> (txd_rise == txd_fall));

  a_r4_upper_bits_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rmii |-> (txd_rise[3:2] == 2'b00 && ctl_fall == ctl_rise));

  a_r5_slow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rmii_slow && act && rep != '0) |-> ($stable(txd_rise) && $stable(ctl_rise)));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rise |-> (txd_rise == 4'h0 && txd_fall == 4'h0 && !ctl_fall));

  a_r9_accept_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && in_valid) |=> ctl_rise);

  a_r9_busy_stays: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> ctl_rise);

endmodule

// File: tb/phy_tx_shaper_test.sv
module phy_tx_shaper_test;
  localparam int CLK_PERIOD = 10;
  localparam int REP = 10;
  localparam int NB = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_rmii = 1'b0;
  logic [1:0] cfg_speed = 2'd2;
  logic [7:0] in_data = 8'h00;
  logic       in_valid = 1'b0;
  logic       in_err = 1'b0;
  logic       in_ready;
  logic [3:0] txd_rise, txd_fall;
  logic       ctl_rise, ctl_fall;

  int checks = 0;
  int fails = 0;

  phy_tx_shaper #(.SLOW_REPEAT(REP)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_rmii(cfg_rmii), .cfg_speed(cfg_speed),
    .in_data(in_data), .in_valid(in_valid), .in_err(in_err), .in_ready(in_ready),
    .txd_rise(txd_rise), .txd_fall(txd_fall), .ctl_rise(ctl_rise), .ctl_fall(ctl_fall)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 5; c++) begin
      int     steps, rp, i, cyc;
      bit     e_act, e_err, e_rdy, v;
      int     e_step;
      logic [7:0] e_byte, b;
      int     er, ef, cr, cf, idx;
      string  mt, ct;

      rst_n = 1'b0;
      in_valid = 1'b0;
      case (c)
        0: begin cfg_rmii = 1'b0; cfg_speed = 2'd2; end
        1: begin cfg_rmii = 1'b0; cfg_speed = 2'd1; end
        2: begin cfg_rmii = 1'b0; cfg_speed = 2'd0; end
        3: begin cfg_rmii = 1'b1; cfg_speed = 2'd1; end
        default: begin cfg_rmii = 1'b1; cfg_speed = 2'd0; end
      endcase
      rp = (cfg_rmii && cfg_speed == 2'd0) ? REP : 1;
      steps = cfg_rmii ? 4 * rp : (cfg_speed[1] ? 1 : 2);
      mt = cfg_rmii ? (rp > 1 ? "R5" : "R4") : (cfg_speed[1] ? "R2" : "R3");
      ct = cfg_rmii ? "R7" : "R6";

      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "txd_rise", txd_rise, 0);
      chk("R1", "txd_fall", txd_fall, 0);
      chk("R1", "ctl", {ctl_rise, ctl_fall}, 0);
      chk("R1", "in_ready", in_ready, 1);
      rst_n = 1'b1;

      e_act = 0; e_err = 0; e_byte = 0; e_step = 0;
      i = 0; cyc = 0;
      while (i < NB || cyc < 8 || e_act) begin
        if (!e_act) begin
          er = 0; ef = 0; cr = 0; cf = 0;
        end else if (cfg_rmii) begin
          idx = e_step / rp;
          er = (e_byte >> (2 * idx)) & 3; ef = er; cr = 1; cf = 1;
        end else if (cfg_speed[1]) begin
          er = e_byte & 4'hf; ef = e_byte >> 4; cr = 1; cf = e_err ? 0 : 1;
        end else begin
          er = (e_step == 0) ? (e_byte & 4'hf) : (e_byte >> 4); ef = er;
          cr = 1; cf = e_err ? 0 : 1;
        end
        chk(e_act ? mt : "R8", "txd_rise", txd_rise, er);
        chk(e_act ? mt : "R8", "txd_fall", txd_fall, ef);
        chk(e_act ? ct : "R8", "ctl_rise", ctl_rise, cr);
        chk(e_act ? ct : "R8", "ctl_fall", ctl_fall, cf);

        e_rdy = !e_act || (e_step == steps - 1);
        chk("R9", "in_ready", in_ready, e_rdy);

        v = (i < NB) && ((cyc % 5) != 2);
        b = 8'((i * 37 + c * 11 + 5) & 8'hff);
        in_valid = v;
        // R9: garbage offered while not ready must be ignored
        in_data = e_rdy ? b : ~b;
        in_err = e_rdy ? (i % 3 == 1) : 1'b1;

        if (e_rdy) begin
          if (v) begin
            e_act = 1; e_byte = b; e_err = (i % 3 == 1); e_step = 0; i++;
          end else begin
            e_act = 0; e_err = 0; e_byte = 0; e_step = 0;
          end
        end else begin
          e_step++;
        end
        if (i >= NB) cyc++;
        @(negedge clk);
      end
      in_valid = 1'b0;
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule